// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves blocks of bytes between a DRAM-side burst port and a PCI-side burst port. Software gives it work in one of two ways. It can write a descriptor straight into the channel's registers and issue a go command. It can also hand over a pointer to the first descriptor of a linked list held in a small descriptor SRAM. The channel then reads each descriptor over its SRAM read port, performs the transfer it describes, and follows the link to the next one. It stops when the list ends.

Each transfer is split into bursts of at most `BURST_BYTES` bytes. Each burst has two legs: the channel first reads from the source side and then writes to the destination side. Each leg uses its own request/grant pair, and the request is raised again from scratch for every burst. The PCI bus is therefore never held across a whole block. The channel picks the PCI command from the direction and from how many bytes remain. A single done pulse and a sticky done flag mark the end of the list. A sticky error flag marks a chain that grew longer than `MAX_CHAIN` descriptors.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset both request outputs are low and the done pulse, done flag and error flag are all 0.
- R2: The CSR port has five word registers. Index 0 is the source address and index 1 the destination address. Index 2 is the control word: bit 31 is the direction (1 = PCI to DRAM), bit 30 is the end mark, and bits [CNT_W-1:0] are the byte count. Index 3 is the link pointer. Writing index 4 runs the descriptor currently held in the registers.
- R3: While a run is in progress, CSR writes are ignored: register writes, go (index 4) and chain start (index 5) all have no effect.
- R4: Writing index 5 with an SRAM word pointer starts a chain. Each descriptor is read as four consecutive SRAM words at pointer+0..3, in the order source, destination, control, link. The SRAM has one cycle of read latency. Descriptors run in list order.
- R5: A descriptor is the last one when its end mark is set or when the low SRAM_AW bits of its link are zero. The SRAM is not read again after the last descriptor.
- R6: DRAM to PCI: each burst is a DRAM read (dram_we = 0) at the source address, followed by a PCI memory write (command 0x7) at the destination address. Command 0xF is never issued.
- R7: PCI to DRAM: each burst is a PCI read at the source address, followed by a DRAM write (dram_we = 1) at the destination address. The read command is 0x6 for a burst shorter than BURST_BYTES. A full burst uses 0xC if more than BURST_BYTES bytes remain, and 0xE otherwise.
- R8: Each burst length is min(remaining, BURST_BYTES). After each burst the remaining count falls by that length, and both addresses advance by the same amount.
- R9: After every PCI grant, pci_req is low in the next cycle, so each PCI burst is requested afresh.
- R10: A descriptor with a zero byte count completes without raising any request.
- R11: When the last descriptor finishes, done_pulse is high for exactly one cycle and done_flag is set. done_flag stays set until the next go or chain start clears it.
- R12: If a chain reaches a further descriptor after MAX_CHAIN descriptors have run, the channel sets err_flag and stops. It raises no done pulse and does no further fetch.
- R13: Only one request is high at a time, and a request keeps its address, length and command stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR register index |
| csr_wdata | input | 32 | CSR write data |
| sram_rd_en | output | 1 | Descriptor SRAM read enable |
| sram_rd_addr | output | SRAM_AW | Descriptor SRAM word address |
| sram_rd_data | input | 32 | SRAM read data, one cycle after the enable |
| dram_req | output | 1 | DRAM burst request |
| dram_gnt | input | 1 | DRAM burst grant |
| dram_we | output | 1 | DRAM burst is a write |
| dram_addr | output | 32 | DRAM burst byte address |
| dram_len | output | $clog2(BURST_BYTES+1) | DRAM burst byte length |
| pci_req | output | 1 | PCI burst request |
| pci_gnt | input | 1 | PCI burst grant |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | PCI burst byte address |
| pci_len | output | $clog2(BURST_BYTES+1) | PCI burst byte length |
| done_pulse | output | 1 | One-cycle pulse when the list completes |
| done_flag | output | 1 | Sticky list-complete flag |
| err_flag | output | 1 | Sticky chain-overrun flag |

## Verification
The assertions check the rules that hold on every cycle:
- the PCI request drops after each grant;
- requests are exclusive and stay stable while waiting for a grant;
- write-and-invalidate never appears;
- burst lengths stay in range;
- the done pulse lasts one cycle;
- registers do not move under CSR writes during a run;
- the chain counter stays bounded.

Only the bench scenarios can show the rest:
- the exact sequence of burst addresses and lengths, and the read-command choice at the tail of a block;
- descriptor fetch order and the stop at the end mark or null link;
- zero-count completion;
- the overrun on a self-linked descriptor.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   typedef enum logic [1:0] {SEQ_IDLE, SEQ_FETCH, SEQ_LAUNCH, SEQ_RUN} seq_st_e;
   typedef enum logic [2:0] {XF_IDLE, XF_LEAD, XF_TRAIL, XF_STEP, XF_FIN} xf_st_e;

   localparam logic [3:0] PCMD_RD      = 4'h6;
   localparam logic [3:0] PCMD_RD_LINE = 4'hE;
   localparam logic [3:0] PCMD_RD_MULT = 4'hC;
   localparam logic [3:0] PCMD_WR      = 4'h7;
   localparam logic [3:0] PCMD_WR_INV  = 4'hF;

   localparam int WORD_W  = 32;
   localparam int CTL_DIR = 31;
   localparam int CTL_END = 30;

   localparam logic [2:0] CSR_SRC   = 3'd0;
   localparam logic [2:0] CSR_DST   = 3'd1;
   localparam logic [2:0] CSR_CTL   = 3'd2;
   localparam logic [2:0] CSR_LINK  = 3'd3;
   localparam logic [2:0] CSR_GO    = 3'd4;
   localparam logic [2:0] CSR_CHAIN = 3'd5;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
   import dma_chain_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [AW-1:0]               ptr,
   output logic                        rd_en,
   output logic [AW-1:0]               rd_addr,
   input  logic [WORD_W-1:0]           rd_data,
   output logic [3:0][WORD_W-1:0]      words,
   output logic                        done
);
   logic          busy;
   logic [1:0]    idx;
   logic [AW-1:0] base;
   logic          cap_v;
   logic [1:0]    cap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         base  <= '0;
         cap_v <= 1'b0;
         cap_i <= '0;
         done  <= 1'b0;
         words <= '0;
      end else begin
         cap_v <= busy;
         cap_i <= idx;
         done  <= cap_v && (cap_i == 2'd3);
         if (cap_v) words[cap_i] <= rd_data;
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            base <= ptr;
         end else if (busy) begin
            idx <= idx + 2'd1;
            if (idx == 2'd3) busy <= 1'b0;
         end
      end
   end

   assign rd_en   = busy;
   assign rd_addr = base + AW'(idx);

   AST_FETCH_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R4
   AST_FETCH_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1))); // R4
endmodule

// File: rtl/dma_xfer_eng.sv
module dma_xfer_eng
   import dma_chain_pkg::*;
#(
   parameter int BURST_BYTES = 16,
   parameter int CNT_W       = 16,
   parameter bit USE_RD_MULT = 1'b1,
   localparam int LEN_W      = $clog2(BURST_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_p2d,
   input  logic [31:0]       src_i,
   input  logic [31:0]       dst_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              dram_req,
   input  logic              dram_gnt,
   output logic              dram_we,
   output logic [31:0]       dram_addr,
   output logic [LEN_W-1:0]  dram_len,
   output logic              pci_req,
   input  logic              pci_gnt,
   output logic [3:0]        pci_cmd,
   output logic [31:0]       pci_addr,
   output logic [LEN_W-1:0]  pci_len,
   output logic              done
);
   localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_BYTES);

   xf_st_e           st;
   logic             dir;
   logic [31:0]      src, dst;
   logic [CNT_W-1:0] rem, blen;
   logic             lead_gnt, trail_gnt, full;
   logic [3:0]       rd_cmd;

   assign blen      = (rem < BURST_C) ? rem : BURST_C;
   assign full      = (blen == BURST_C);
   assign lead_gnt  = dir ? pci_gnt : dram_gnt;
   assign trail_gnt = dir ? dram_gnt : pci_gnt;

   generate
      if (USE_RD_MULT) begin : g_rd_mult
         assign rd_cmd = !full ? PCMD_RD : ((rem > BURST_C) ? PCMD_RD_MULT : PCMD_RD_LINE);
      end else begin : g_rd_line
         assign rd_cmd = !full ? PCMD_RD : PCMD_RD_LINE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= XF_IDLE;
         dir <= 1'b0;
         src <= '0;
         dst <= '0;
         rem <= '0;
      end else begin
         case (st)
            XF_IDLE: if (start) begin
               dir <= dir_p2d;
               src <= src_i;
               dst <= dst_i;
               rem <= cnt_i;
               st  <= (cnt_i == '0) ? XF_FIN : XF_LEAD;
            end
            XF_LEAD:  if (lead_gnt)  st <= XF_TRAIL;
            XF_TRAIL: if (trail_gnt) st <= XF_STEP;
            XF_STEP: begin
               rem <= rem - blen;
               src <= src + 32'(blen);
               dst <= dst + 32'(blen);
               st  <= (rem == blen) ? XF_FIN : XF_LEAD;
            end
            XF_FIN:  st <= XF_IDLE;
            default: st <= XF_IDLE;
         endcase
      end
   end

   assign dram_req  = ((st == XF_LEAD) && !dir) || ((st == XF_TRAIL) && dir);
   assign pci_req   = ((st == XF_LEAD) && dir) || ((st == XF_TRAIL) && !dir);
   assign dram_we   = dir;
   assign dram_addr = dir ? dst : src;
   assign pci_addr  = dir ? src : dst;
   assign dram_len  = blen[LEN_W-1:0];
   assign pci_len   = blen[LEN_W-1:0];
   assign pci_cmd   = dir ? rd_cmd : PCMD_WR;
   assign done      = (st == XF_FIN);

   AST_NO_WR_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
      pci_req |-> (pci_cmd != PCMD_WR_INV)); // R6
   AST_PCI_REARB: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_req && pci_gnt) |=> !pci_req); // R9
   AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_req && pci_req)); // R13
   AST_PCI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_req && !pci_gnt) |=> (pci_req && $stable(pci_addr) && $stable(pci_cmd) && $stable(pci_len))); // R13
   AST_DRAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_req && !dram_gnt) |=> (dram_req && $stable(dram_addr) && $stable(dram_we) && $stable(dram_len))); // R13
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_req || pci_req) |-> (dram_len != '0 && dram_len <= LEN_W'(BURST_BYTES))); // R8
   AST_ZERO_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (start && st == XF_IDLE && cnt_i == '0) |=> (!dram_req && !pci_req)); // R10
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
   import dma_chain_pkg::*;
#(
   parameter int SRAM_AW     = 8,
   parameter int CNT_W       = 16,
   parameter int BURST_BYTES = 16,
   parameter int MAX_CHAIN   = 16,
   parameter bit USE_RD_MULT = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             csr_wr,
   input  logic [2:0]                       csr_addr,
   input  logic [31:0]                      csr_wdata,
   output logic                             sram_rd_en,
   output logic [SRAM_AW-1:0]               sram_rd_addr,
   input  logic [31:0]                      sram_rd_data,
   output logic                             dram_req,
   input  logic                             dram_gnt,
   output logic                             dram_we,
   output logic [31:0]                      dram_addr,
   output logic [$clog2(BURST_BYTES+1)-1:0] dram_len,
   output logic                             pci_req,
   input  logic                             pci_gnt,
   output logic [3:0]                       pci_cmd,
   output logic [31:0]                      pci_addr,
   output logic [$clog2(BURST_BYTES+1)-1:0] pci_len,
   output logic                             done_pulse,
   output logic                             done_flag,
   output logic                             err_flag
);
   localparam int CHN_W = $clog2(MAX_CHAIN + 1);

   generate
      if (BURST_BYTES < 8 || (BURST_BYTES % 8) != 0) begin : g_bad_burst
         $error("BURST_BYTES must be a positive multiple of 8");
      end
      if (CNT_W > 30 || CNT_W < $clog2(BURST_BYTES + 1)) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (SRAM_AW < 3 || SRAM_AW > 30) begin : g_bad_aw
         $error("SRAM_AW out of range");
      end
      if (MAX_CHAIN < 1) begin : g_bad_chain
         $error("MAX_CHAIN must be at least 1");
      end
   endgenerate

   seq_st_e              seq;
   logic [31:0]          r_src, r_dst;
   logic                 r_dir, r_end;
   logic [CNT_W-1:0]     r_cnt;
   logic [SRAM_AW-1:0]   r_link;
   logic [CHN_W-1:0]     chain_n;
   logic                 idle, csr_go, csr_chain, is_last;
   logic                 run_next, fetch_start, fetch_done, xdone;
   logic [SRAM_AW-1:0]   fetch_ptr;
   logic [3:0][31:0]     fwords;

   assign idle        = (seq == SEQ_IDLE);
   assign csr_go      = csr_wr && idle && (csr_addr == CSR_GO);
   assign csr_chain   = csr_wr && idle && (csr_addr == CSR_CHAIN);
   assign is_last     = r_end || (r_link == '0);
   assign run_next    = (seq == SEQ_RUN) && xdone && !is_last && (chain_n != CHN_W'(MAX_CHAIN));
   assign fetch_start = csr_chain || run_next;
   assign fetch_ptr   = csr_chain ? csr_wdata[SRAM_AW-1:0] : r_link;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq        <= SEQ_IDLE;
         r_src      <= '0;
         r_dst      <= '0;
         r_dir      <= 1'b0;
         r_end      <= 1'b0;
         r_cnt      <= '0;
         r_link     <= '0;
         chain_n    <= '0;
         done_pulse <= 1'b0;
         done_flag  <= 1'b0;
         err_flag   <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         case (seq)
            SEQ_IDLE: begin
               if (csr_wr) begin
                  case (csr_addr)
                     CSR_SRC:  r_src <= csr_wdata;
                     CSR_DST:  r_dst <= csr_wdata;
                     CSR_CTL: begin
                        r_dir <= csr_wdata[CTL_DIR];
                        r_end <= csr_wdata[CTL_END];
                        r_cnt <= csr_wdata[CNT_W-1:0];
                     end
                     CSR_LINK: r_link <= csr_wdata[SRAM_AW-1:0];
                     default: ;
                  endcase
               end
               if (csr_go || csr_chain) begin
                  chain_n   <= '0;
                  done_flag <= 1'b0;
                  err_flag  <= 1'b0;
                  seq       <= csr_go ? SEQ_LAUNCH : SEQ_FETCH;
               end
            end
            SEQ_FETCH: if (fetch_done) begin
               r_src  <= fwords[0];
               r_dst  <= fwords[1];
               r_dir  <= fwords[2][CTL_DIR];
               r_end  <= fwords[2][CTL_END];
               r_cnt  <= fwords[2][CNT_W-1:0];
               r_link <= fwords[3][SRAM_AW-1:0];
               seq    <= SEQ_LAUNCH;
            end
            SEQ_LAUNCH: begin
               chain_n <= chain_n + CHN_W'(1);
               seq     <= SEQ_RUN;
            end
            SEQ_RUN: if (xdone) begin
               if (is_last) begin
                  done_pulse <= 1'b1;
                  done_flag  <= 1'b1;
                  seq        <= SEQ_IDLE;
               end else if (run_next) begin
                  seq <= SEQ_FETCH;
               end else begin
                  err_flag <= 1'b1;
                  seq      <= SEQ_IDLE;
               end
            end
            default: seq <= SEQ_IDLE;
         endcase
      end
   end

   dma_desc_fetch #(.AW(SRAM_AW)) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fetch_start),
      .ptr     (fetch_ptr),
      .rd_en   (sram_rd_en),
      .rd_addr (sram_rd_addr),
      .rd_data (sram_rd_data),
      .words   (fwords),
      .done    (fetch_done)
   );

   dma_xfer_eng #(
      .BURST_BYTES (BURST_BYTES),
      .CNT_W       (CNT_W),
      .USE_RD_MULT (USE_RD_MULT)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (seq == SEQ_LAUNCH),
      .dir_p2d   (r_dir),
      .src_i     (r_src),
      .dst_i     (r_dst),
      .cnt_i     (r_cnt),
      .dram_req  (dram_req),
      .dram_gnt  (dram_gnt),
      .dram_we   (dram_we),
      .dram_addr (dram_addr),
      .dram_len  (dram_len),
      .pci_req   (pci_req),
      .pci_gnt   (pci_gnt),
      .pci_cmd   (pci_cmd),
      .pci_addr  (pci_addr),
      .pci_len   (pci_len),
      .done      (xdone)
   );

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse); // R11
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_flag && err_flag)); // R12
   AST_CHAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      chain_n <= CHN_W'(MAX_CHAIN)); // R12
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SEQ_RUN && csr_wr) |=> ($stable(r_src) && $stable(r_dst) && $stable(r_cnt) && $stable(r_link))); // R3
   AST_SRAM_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      sram_rd_en |-> (seq == SEQ_FETCH)); // R4
   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> done_flag); // R11
endmodule

// File: tb/sim_dma_chain_chan.sv
module sim_dma_chain_chan;
   localparam int CLK_PERIOD = 10;
   localparam int BB = 16;
   localparam int LW = $clog2(BB + 1);

   logic clk = 1'b0;
   logic rst_n;
   logic csr_wr;
   logic [2:0] csr_addr;
   logic [31:0] csr_wdata;
   logic sram_rd_en;
   logic [7:0] sram_rd_addr;
   logic [31:0] sram_rd_data;
   logic dram_req, dram_gnt, dram_we;
   logic [31:0] dram_addr;
   logic [LW-1:0] dram_len;
   logic pci_req, pci_gnt;
   logic [3:0] pci_cmd;
   logic [31:0] pci_addr;
   logic [LW-1:0] pci_len;
   logic done_pulse, done_flag, err_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chain_chan u0 (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .sram_rd_en(sram_rd_en), .sram_rd_addr(sram_rd_addr), .sram_rd_data(sram_rd_data),
      .dram_req(dram_req), .dram_gnt(dram_gnt), .dram_we(dram_we), .dram_addr(dram_addr),
      .dram_len(dram_len), .pci_req(pci_req), .pci_gnt(pci_gnt), .pci_cmd(pci_cmd),
      .pci_addr(pci_addr), .pci_len(pci_len), .done_pulse(done_pulse),
      .done_flag(done_flag), .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_fail = 0;
   int gnt_wait = 0;
   int dw = 0, pw = 0;
   logic [31:0] mem [0:255];
   logic [31:0] rd_next = '0;

   logic [4:0]  lg_kind [0:255];
   logic [31:0] lg_addr [0:255];
   logic [7:0]  lg_len  [0:255];
   int n_log = 0;
   logic [4:0]  ex_kind [0:255];
   logic [31:0] ex_addr [0:255];
   logic [7:0]  ex_len  [0:255];
   int n_exp = 0;
   logic [7:0] rd_log [0:255];
   int n_rd = 0;
   int n_done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // SRAM model with one cycle of read latency, plus grant models and logs
   always @(negedge clk) begin
      sram_rd_data = rd_next;
      rd_next = sram_rd_en ? mem[sram_rd_addr] : 32'h0;
      if (sram_rd_en && n_rd < 256) begin rd_log[n_rd] = sram_rd_addr; n_rd++; end
      if (done_pulse) n_done++;
      if (dram_gnt) begin
         dram_gnt = 1'b0; dw = 0;
      end else if (dram_req) begin
         if (dw >= gnt_wait) begin
            dram_gnt = 1'b1;
            if (n_log < 256) begin
               lg_kind[n_log] = {4'b0, dram_we}; lg_addr[n_log] = dram_addr;
               lg_len[n_log] = 8'(dram_len); n_log++;
            end
         end else dw++;
      end
      if (pci_gnt) begin
         chk(!pci_req, "R9", "pci_req one cycle after grant", 64'(pci_req), 64'h0);
         pci_gnt = 1'b0; pw = 0;
      end else if (pci_req) begin
         if (pw >= gnt_wait) begin
            pci_gnt = 1'b1;
            if (n_log < 256) begin
               lg_kind[n_log] = {1'b1, pci_cmd}; lg_addr[n_log] = pci_addr;
               lg_len[n_log] = 8'(pci_len); n_log++;
            end
         end else pw++;
      end
   end

   function automatic logic [31:0] mk_ctl(input bit p2d, input bit endf, input int cnt);
      return {p2d, endf, 14'b0, 16'(cnt)};
   endfunction

   task automatic put_exp(input logic [4:0] k, input logic [31:0] a, input int l);
      ex_kind[n_exp] = k; ex_addr[n_exp] = a; ex_len[n_exp] = 8'(l); n_exp++;
   endtask

   // expected bursts derived from R6, R7, R8
   task automatic add_desc(input bit p2d, input logic [31:0] s, input logic [31:0] d, input int cnt);
      int rem = cnt;
      logic [31:0] sa = s, da = d;
      while (rem > 0) begin
         int len = (rem < BB) ? rem : BB;
         if (!p2d) begin
            put_exp(5'h00, sa, len);
            put_exp(5'h17, da, len);
         end else begin
            logic [3:0] c = (len < BB) ? 4'h6 : ((rem > BB) ? 4'hC : 4'hE);
            put_exp({1'b1, c}, sa, len);
            put_exp(5'h01, da, len);
         end
         sa += 32'(len); da += 32'(len); rem -= len;
      end
   endtask

   task automatic clear_logs();
      n_log = 0; n_exp = 0; n_rd = 0; n_done = 0;
   endtask

   task automatic cmp_log(input string req);
      chk(n_log == n_exp, req, "burst count", 64'(n_log), 64'(n_exp));
      for (int i = 0; i < n_exp && i < n_log; i++) begin
         chk(lg_kind[i] == ex_kind[i], req, $sformatf("burst %0d kind", i), 64'(lg_kind[i]), 64'(ex_kind[i]));
         chk(lg_addr[i] == ex_addr[i], req, $sformatf("burst %0d addr", i), 64'(lg_addr[i]), 64'(ex_addr[i]));
         chk(lg_len[i] == ex_len[i], req, $sformatf("burst %0d len", i), 64'(lg_len[i]), 64'(ex_len[i]));
      end
   endtask

   task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk); csr_wr = 1'b0;
   endtask

   task automatic wait_end(input string req);
      int t = 0;
      while (!(done_flag || err_flag) && t < 2000) begin @(negedge clk); t++; end
      chk(t < 2000, req, "run finished", 64'(t), 64'd2000);
      repeat (3) @(negedge clk);
   endtask

   task automatic put_desc(input int p, input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] c, input logic [31:0] l);
      mem[p] = s; mem[p+1] = d; mem[p+2] = c; mem[p+3] = l;
   endtask

   task automatic t_reset();
      chk(!dram_req && !pci_req, "R1", "requests after reset", {dram_req, pci_req}, 0);
      chk(!done_pulse && !done_flag && !err_flag, "R1", "flags after reset",
          {done_pulse, done_flag, err_flag}, 0);
   endtask

   task automatic t_direct_d2p();
      clear_logs(); gnt_wait = 0;
      csr_write(3'd0, 32'h1000_0003);
      csr_write(3'd1, 32'h8000_0010);
      csr_write(3'd2, mk_ctl(1'b0, 1'b1, 40));
      csr_write(3'd3, 32'h0);
      csr_write(3'd4, 32'h0);
      add_desc(1'b0, 32'h1000_0003, 32'h8000_0010, 40);
      wait_end("R2");
      cmp_log("R6");
      chk(n_done == 1, "R11", "done pulse count", 64'(n_done), 64'd1);
      chk(done_flag && !err_flag, "R11", "done flag set", {done_flag, err_flag}, 64'h2);
      chk(n_rd == 0, "R2", "no SRAM reads for direct descriptor", 64'(n_rd), 64'd0);
      repeat (5) @(negedge clk);
      chk(done_flag, "R11", "done flag sticky", 64'(done_flag), 64'd1);
   endtask

   task automatic t_busy_ignore();
      clear_logs(); gnt_wait = 3;
      csr_write(3'd0, 32'h4000_0000);
      csr_write(3'd1, 32'h0000_1008);
      csr_write(3'd2, mk_ctl(1'b1, 1'b0, 48));
      csr_write(3'd3, 32'h0);
      csr_write(3'd4, 32'h0);
      chk(!done_flag, "R11", "done flag cleared by start", 64'(done_flag), 64'd0);
      repeat (6) @(negedge clk);
      csr_write(3'd0, 32'hDEAD_0000);
      csr_write(3'd1, 32'hBEEF_0000);
      csr_write(3'd4, 32'h0);
      csr_write(3'd5, 32'h10);
      add_desc(1'b1, 32'h4000_0000, 32'h0000_1008, 48);
      wait_end("R3");
      cmp_log("R3");
      repeat (20) @(negedge clk);
      chk(n_log == n_exp, "R3", "no extra bursts after ignored writes", 64'(n_log), 64'(n_exp));
      chk(n_done == 1 && n_rd == 0, "R3", "single run, no fetch", {32'(n_done), 32'(n_rd)}, {32'd1, 32'd0});
   endtask

   task automatic t_p2d_tail();
      clear_logs(); gnt_wait = 1;
      csr_write(3'd0, 32'h0000_2000);
      csr_write(3'd1, 32'h0300_0001);
      csr_write(3'd2, mk_ctl(1'b1, 1'b1, 20));
      csr_write(3'd4, 32'h0);
      add_desc(1'b1, 32'h0000_2000, 32'h0300_0001, 20);
      wait_end("R7");
      cmp_log("R7");
   endtask

   task automatic t_chain();
      clear_logs(); gnt_wait = 1;
      put_desc(16'h10, 32'h2000_0005, 32'h9000_0000, mk_ctl(1'b0, 1'b0, 24), 32'h20);
      put_desc(16'h20, 32'h5555_0000, 32'h6666_0000, mk_ctl(1'b1, 1'b0, 0), 32'h30);
      put_desc(16'h30, 32'h9100_0000, 32'h2100_0004, mk_ctl(1'b1, 1'b0, 36), 32'h0);
      csr_write(3'd5, 32'h10);
      add_desc(1'b0, 32'h2000_0005, 32'h9000_0000, 24);
      add_desc(1'b1, 32'h9100_0000, 32'h2100_0004, 36);
      wait_end("R4");
      cmp_log("R8");
      chk(n_rd == 12, "R4", "SRAM read count", 64'(n_rd), 64'd12);
      for (int i = 0; i < 12 && i < n_rd; i++) begin
         logic [7:0] e = 8'(16 * (i / 4 + 1) + i % 4);
         chk(rd_log[i] == e, "R4", $sformatf("SRAM read %0d", i), 64'(rd_log[i]), 64'(e));
      end
      chk(n_done == 1, "R11", "one done pulse for chain", 64'(n_done), 64'd1);
   endtask

   task automatic t_end_mark();
      clear_logs(); gnt_wait = 0;
      put_desc(16'h40, 32'h0000_0100, 32'h0000_0200, mk_ctl(1'b0, 1'b1, 8), 32'h50);
      put_desc(16'h50, 32'h0000_0300, 32'h0000_0400, mk_ctl(1'b0, 1'b0, 8), 32'h0);
      csr_write(3'd5, 32'h40);
      add_desc(1'b0, 32'h0000_0100, 32'h0000_0200, 8);
      wait_end("R5");
      cmp_log("R5");
      chk(n_rd == 4, "R5", "no fetch past end mark", 64'(n_rd), 64'd4);
   endtask

   task automatic t_zero_direct();
      clear_logs();
      csr_write(3'd2, mk_ctl(1'b0, 1'b1, 0));
      csr_write(3'd4, 32'h0);
      wait_end("R10");
      chk(n_log == 0, "R10", "zero count makes no request", 64'(n_log), 64'd0);
      chk(n_done == 1 && done_flag, "R10", "zero count completes", {32'(n_done), 31'b0, done_flag}, {32'd1, 32'd1});
   endtask

   task automatic t_loop_guard();
      clear_logs();
      put_desc(16'h60, 32'h0, 32'h0, mk_ctl(1'b0, 1'b0, 0), 32'h60);
      csr_write(3'd5, 32'h60);
      wait_end("R12");
      repeat (10) @(negedge clk);
      chk(err_flag && !done_flag, "R12", "overrun flags", {err_flag, done_flag}, 64'h2);
      chk(n_done == 0, "R12", "no done pulse on overrun", 64'(n_done), 64'd0);
      chk(n_rd == 64, "R12", "fetches before overrun", 64'(n_rd), 64'd64);
      csr_write(3'd4, 32'h0);
      chk(!err_flag, "R12", "error flag cleared by start", 64'(err_flag), 64'd0);
      wait_end("R11");
   endtask

   task automatic finish_tb();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_tb();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      rst_n = 1'b0; csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
      dram_gnt = 1'b0; pci_gnt = 1'b0; sram_rd_data = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct_d2p();
      t_busy_ignore();
      t_p2d_tail();
      t_chain();
      t_end_mark();
      t_zero_direct();
      t_loop_guard();
      finish_tb();
   end
endmodule